// File: doc/BRIEF.md
# Glitch-Free Gated Clock Fanout

This block takes two clock sources, a fast system clock and a slower scan or test clock, and picks one of them with a select input. The picked clock goes through a single gate and out to a bank of identical outputs. A common hold-off control stops the outputs, and only at safe points in the waveform. A flip-flop clocked on the falling edge of the picked clock captures the control. A stop or a restart therefore lands while the clock is already low, and no output pulse is ever cut short.

The gate is an AND of the picked clock with that flop's output. The flop has an asynchronous active-low reset, and reset leaves the block stopped. All outputs come from one gated net. The select should only change while the outputs are stopped.

Top module: `gated_clk_fanout`

## Requirements
- R1: With `use_scan` = 0 the outputs follow `sys_clk`: high during its high phases and low during its low phases, whatever `scan_clk` is doing.
- R2: With `use_scan` = 1 the outputs follow `scan_clk`, whatever `sys_clk` is doing.
- R3: `hold_off` = 1 means stop. It is sampled on the falling edge of the selected clock, and from that edge on the outputs stay low. A high phase already in progress when `hold_off` rises is completed in full.
- R4: An output is never high while the selected clock is low.
- R5: `hold_off` = 0 means run, and it also takes effect only at a falling edge of the selected clock. A drop of `hold_off` during a low phase leaves the following high phase stopped. The first pulse after the restart is a whole high phase.
- R6: All `N_OUT` outputs (default 4) carry identical values at all times.
- R7: While `rst_n` = 0 the outputs are low. After `rst_n` returns to 1, the block stays stopped until the first falling edge of the selected clock that samples `hold_off` = 0.
- R8: Every output pulse is exactly as wide as the high phase of the selected clock, so no runt pulse appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Fast system clock source |
| scan_clk | input | 1 | Slow scan/test clock source |
| use_scan | input | 1 | Source select: 0 = system clock, 1 = scan clock |
| rst_n | input | 1 | Asynchronous active-low reset; leaves the block stopped |
| hold_off | input | 1 | 1 = stop the outputs, 0 = run; acts at falling edges of the selected clock |
| clk_out | output | N_OUT | Identical copies of the gated clock |

## Verification
The bench sweeps both sources, both starting states and both target states. It moves the hold-off control either in mid-high or in mid-low phase. A change in mid-high shows that the pulse in progress finishes unchanged. A change in mid-low shows that the next pulse is still governed by the old state, so the effect waits for a falling edge. The system clock's high and low phases are sampled while the scan clock sits at both levels, which shows whether the mux picks the right source. A width monitor on every output pulse compares it with the selected high phase, and a wrong source, a chopped pulse or a glitch each shows up there.

// File: rtl/gated_clk_fanout.sv
module gated_clk_fanout #(
  parameter int N_OUT = 4
) (
  input  logic             sys_clk,
  input  logic             scan_clk,
  input  logic             use_scan,
  input  logic             rst_n,
  input  logic             hold_off,
  output logic [N_OUT-1:0] clk_out
);

  logic src_clk;
  logic pass_q;
  logic gated;

  assign src_clk = use_scan ? scan_clk : sys_clk;

  always_ff @(negedge src_clk or negedge rst_n)
    if (!rst_n) pass_q <= 1'b0;
    else        pass_q <= ~hold_off;

  assign gated   = src_clk & pass_q;
  assign clk_out = {N_OUT{gated}};

endmodule

// File: rtl/gated_clk_fanout_chk.sv
module gated_clk_fanout_chk #(
  parameter int N_OUT = 4
) (
  input logic             sys_clk,
  input logic             scan_clk,
  input logic             use_scan,
  input logic             rst_n,
  input logic             hold_off,
  input logic [N_OUT-1:0] clk_out
);

  logic mclk;
  assign mclk = use_scan ? scan_clk : sys_clk;

  always @(posedge sys_clk)
    if (!rst_n) AST_RESET_LOW: assert (clk_out == '0); // R7

  AST_NO_HIGH_WHEN_SRC_LOW: assert property (@(posedge mclk) disable iff (!rst_n)
    clk_out == '0); // R4

  AST_COPIES_EQUAL: assert property (@(negedge mclk) disable iff (!rst_n)
    (clk_out == '0) || (clk_out == '1)); // R6

  AST_STOP_AT_FALL: assert property (@(negedge mclk) disable iff (!rst_n)
    ($past(hold_off) && $stable(use_scan)) |-> clk_out == '0); // R3

  AST_RUN_FULL_PHASE: assert property (@(negedge mclk) disable iff (!rst_n)
    ($past(!hold_off) && $past(rst_n) && $stable(use_scan)) |-> clk_out == '1); // R5

endmodule

bind gated_clk_fanout gated_clk_fanout_chk #(.N_OUT(N_OUT)) u_chk (
  .sys_clk  (sys_clk),
  .scan_clk (scan_clk),
  .use_scan (use_scan),
  .rst_n    (rst_n),
  .hold_off (hold_off),
  .clk_out  (clk_out)
);

// File: tb/test_gated_clk_fanout.sv
`timescale 1ns/1ps
module test_gated_clk_fanout;
  localparam int N = 4;
  localparam int SYS_H  = 2;
  localparam int SCAN_H = 10;

  logic sys_clk = 0, scan_clk = 0, use_scan = 0, rst_n = 1, hold_off = 0;
  logic [N-1:0] clk_out;
  int checks = 0, errors = 0;
  bit done = 0;
  realtime t_rise = 0;

  gated_clk_fanout #(.N_OUT(N)) i_gated_clk_fanout (
    .sys_clk(sys_clk), .scan_clk(scan_clk), .use_scan(use_scan),
    .rst_n(rst_n), .hold_off(hold_off), .clk_out(clk_out));

  initial forever #(SYS_H)  sys_clk  = ~sys_clk;
  initial forever #(SCAN_H) scan_clk = ~scan_clk;

  localparam logic [N-1:0] HI = '1;
  localparam logic [N-1:0] LO = '0;

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // R8 / R1 / R2: pulse width equals high phase of selected source
  always @(posedge clk_out[0]) t_rise = $realtime;
  always @(negedge clk_out[0]) if (rst_n) begin
    realtime w, e;
    w = $realtime - t_rise;
    e = use_scan ? SCAN_H : SYS_H;
    checks++;
    if (w < e - 0.001 || w > e + 0.001) begin
      errors++;
      $display("FAIL R8 pulse width at %0t: actual %0.3f expected %0.3f", $time, w, e);
    end
  end

  task automatic rise_mid();
    if (use_scan) begin @(posedge scan_clk); #(SCAN_H/2); end
    else          begin @(posedge sys_clk);  #(SYS_H/2);  end
  endtask
  task automatic fall_mid();
    if (use_scan) begin @(negedge scan_clk); #(SCAN_H/2); end
    else          begin @(negedge sys_clk);  #(SYS_H/2);  end
  endtask

  initial begin
    #1 rst_n = 0;
    // R7: held in reset with hold_off low, outputs stay low
    for (int i = 0; i < 4; i++) begin
      rise_mid(); chk("R7 in reset", clk_out, LO);
    end
    rst_n = 1;              // released mid-high
    chk("R7 release phase", clk_out, LO);
    rise_mid(); chk("R7 first pulse after release", clk_out, HI);
    fall_mid(); chk("R1 low phase", clk_out, LO);

    for (int s = 0; s < 2; s++)
      for (int o = 0; o < 2; o++)
        for (int n = 0; n < 2; n++)
          for (int p = 0; p < 2; p++) begin
            hold_off = 1;
            rise_mid(); rise_mid();
            use_scan = s[0];
            rise_mid(); rise_mid();
            chk(s ? "R2 stopped" : "R1 stopped", clk_out, LO);
            fall_mid(); hold_off = ~o[0];
            rise_mid(); rise_mid();
            chk(s ? "R2 run state" : "R1 run state", clk_out, o ? HI : LO);
            fall_mid();
            chk(s ? "R2 low phase" : "R1 low phase", clk_out, LO);
            if (p == 0) begin
              rise_mid(); hold_off = ~n[0];
              chk("R3/R5 phase in progress kept", clk_out, o ? HI : LO);
              fall_mid(); chk("R4 low phase", clk_out, LO);
              rise_mid(); chk(n ? "R5 restart full pulse" : "R3 stopped after fall", clk_out, n ? HI : LO);
            end else begin
              hold_off = ~n[0];
              rise_mid(); chk("R3/R5 waits for fall", clk_out, o ? HI : LO);
              fall_mid(); chk("R4 low phase", clk_out, LO);
              rise_mid(); chk(n ? "R5 restart full pulse" : "R3 stopped after fall", clk_out, n ? HI : LO);
            end
          end

    // R1: system clock sampled while scan clock is high and low
    hold_off = 1; rise_mid(); rise_mid();
    use_scan = 0; rise_mid(); rise_mid();
    hold_off = 0; rise_mid();
    for (int i = 0; i < 12; i++) begin
      rise_mid(); chk("R1 high follows sys_clk", clk_out, HI);
      fall_mid(); chk("R1 low follows sys_clk", clk_out, LO);
    end
    // R6: copies identical across a run
    for (int i = 0; i < 6; i++) begin
      rise_mid();
      chk("R6 copies equal", {N{clk_out[0]}}, clk_out);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule